// File: doc/BRIEF.md
# Bit-Addressed Control Register

A 16-bit control register that a host fills one bit at a time over a serial-style I/O bus. A single write carries everything at once: the address says which bit, and the least significant address line carries the value to store. The block checks the upper address field against one of eight base slots chosen by a 3-bit strap input. It splits the register into two 8-bit groups and updates the one addressed flip-flop. There is no read path.

The 16 register bits come out in parallel. Bit 0 enables the card's memory window and lights an indicator. Bit 15 enables an auxiliary paging window. Bits 1 to 13 are page-select lines for the memory behind the card, and bit 14 is a spare. Writes are captured on the rising clock edge where the active-low strobe is asserted and the address matches. Reset is synchronous and active high.

Top module: `bitwise_ctl_reg`

## Requirements
- R1: A clock edge with `rst` high clears all 16 register bits.
- R2: Nothing is written while `strobe_n` is high, whatever the address.
- R3: A write is taken only when address bit A3 is 1, A4 is 0 and {A5,A6,A7} equals `base_sel`. The bus numbers A0 as the most significant bit and A15 as the least, so the matched base is 0x1000 + 0x100*`base_sel`. Any other value of these bits changes nothing.
- R4: The target bit is {A11,A12,A13,A14}, which is bits 4..1 of the address value. A11 low selects bits 0-7 and A11 high selects bits 8-15. The stored value is A15, which is bit 0 of the address value.
- R5: A write changes only the addressed bit. The other 15 bits keep their values.
- R6: The new value shows on `ctrl_q` right after the clock edge that sampled the strobe and the matching address, with no earlier pass-through.
- R7: `card_en` and `card_led` follow register bit 0, and `aux_en` follows register bit 15.
- R8: Address bits A0-A2 and A8-A10 play no part in the match.
- R9: When a write and `rst` fall on the same edge, the reset wins and all bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_n | input | 1 | Active-low output strobe of the I/O bus |
| io_addr | input | 16 | I/O address; index 0 is A0 (MSB), index 15 is A15, which also carries the data bit |
| base_sel | input | 3 | Strap choosing one of eight base slots |
| ctrl_q | output | 16 | All register bits |
| card_en | output | 1 | Memory window enable (bit 0) |
| card_led | output | 1 | Indicator drive (bit 0) |
| aux_en | output | 1 | Auxiliary paging window enable (bit 15) |

## Verification
Two things can land on the same edge: a valid bit write and the synchronous reset. The bench makes this happen by asserting `rst` during a cycle that also carries a matching, strobed write of a 1. It then expects the register to read all zeros afterwards. It also places strobed writes straight after a reset release and before a write that has no strobe. This shows that each edge acts only on what it sampled.

// File: rtl/bitwise_ctl_reg_pkg.sv
package bitwise_ctl_reg_pkg;

    localparam int ADDR_W   = 16;
    localparam int GRP_W    = 8;
    localparam int NUM_GRP  = 2;
    localparam int REG_W    = GRP_W * NUM_GRP;
    localparam int IDX_W    = $clog2(GRP_W);
    localparam int GSEL_W   = $clog2(NUM_GRP);
    localparam int SLOT_W   = 3;

    // Field positions in MSB-first bus numbering (index 0 = A0 = MSB)
    localparam int POS_ONE  = 3;
    localparam int POS_ZERO = 4;
    localparam int POS_SLOT = 5;
    localparam int POS_GRP  = 11;
    localparam int POS_IDX  = POS_GRP + GSEL_W;
    localparam int POS_DATA = ADDR_W - 1;

    localparam int BIT_CARD = 0;
    localparam int BIT_AUX  = REG_W - 1;

    typedef logic [0:ADDR_W-1] bus_addr_t;

    typedef struct packed {
        logic              hit;
        logic [GSEL_W-1:0] grp;
        logic [IDX_W-1:0]  idx;
        logic              val;
    } wr_req_t;

    // Bits that take part in the base match
    function automatic bus_addr_t care_mask();
        bus_addr_t m = '0;
        m[POS_ONE]  = 1'b1;
        m[POS_ZERO] = 1'b1;
        for (int i = 0; i < SLOT_W; i++) m[POS_SLOT + i] = 1'b1;
        return m;
    endfunction

    // Expected value of the cared-for bits for a given slot
    function automatic bus_addr_t match_pattern(logic [SLOT_W-1:0] slot);
        bus_addr_t p = '0;
        p[POS_ONE] = 1'b1;
        for (int i = 0; i < SLOT_W; i++) p[POS_SLOT + i] = slot[SLOT_W-1-i];
        return p;
    endfunction

endpackage

// File: rtl/bitwise_ctl_reg_decode.sv
module bitwise_ctl_reg_decode
    import bitwise_ctl_reg_pkg::*;
(
    input  logic                strobe_n,
    input  bus_addr_t           io_addr,
    input  logic [SLOT_W-1:0]   base_sel,
    output wr_req_t             req
);
    localparam bus_addr_t CARE = care_mask();

    bus_addr_t pattern;
    logic      base_hit;

    always_comb begin
        pattern  = match_pattern(base_sel);
        base_hit = ((io_addr ^ pattern) & CARE) == '0;
        req.hit  = base_hit && !strobe_n;
        req.grp  = io_addr[POS_GRP +: GSEL_W];
        req.idx  = io_addr[POS_IDX +: IDX_W];
        req.val  = io_addr[POS_DATA];
    end
endmodule

// File: rtl/bitwise_ctl_reg_group.sv
module bitwise_ctl_reg_group
    import bitwise_ctl_reg_pkg::*;
#(
    parameter int GRP_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    output logic [GRP_W-1:0] q
);
    logic grp_sel;
    assign grp_sel = req.hit && (req.grp == GSEL_W'(GRP_ID));

    for (genvar b = 0; b < GRP_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[b] <= 1'b0;
            else if (grp_sel && (req.idx == IDX_W'(b)))
                q[b] <= req.val;
        end
    end
endmodule

// File: rtl/bitwise_ctl_reg.sv
module bitwise_ctl_reg
    import bitwise_ctl_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n,
    input  logic [0:15]       io_addr,
    input  logic [2:0]        base_sel,
    output logic [15:0]       ctrl_q,
    output logic              card_en,
    output logic              card_led,
    output logic              aux_en
);
    wr_req_t req;

    bitwise_ctl_reg_decode i_decode (
        .strobe_n (strobe_n),
        .io_addr  (io_addr),
        .base_sel (base_sel),
        .req      (req)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        bitwise_ctl_reg_group #(.GRP_ID(g)) i_group (
            .clk (clk),
            .rst (rst),
            .req (req),
            .q   (ctrl_q[g*GRP_W +: GRP_W])
        );
    end

    assign card_en  = ctrl_q[BIT_CARD];
    assign card_led = ctrl_q[BIT_CARD];
    assign aux_en   = ctrl_q[BIT_AUX];
endmodule

// File: rtl/bitwise_ctl_reg_chk.sv
module bitwise_ctl_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        strobe_n,
    input logic [0:15] io_addr,
    input logic [2:0]  base_sel,
    input logic [15:0] ctrl_q,
    input logic        card_en,
    input logic        card_led,
    input logic        aux_en
);
    logic [15:0] a_val;
    logic        hit;
    logic [3:0]  idx;
    logic [3:0]  prev_idx;
    logic        prev_val;

    always_comb begin
        a_val = io_addr;
        hit   = !strobe_n && ((a_val & 16'h1F00) == (16'h1000 | {5'b0, base_sel, 8'h00}));
        idx   = a_val[4:1];
    end

    always_ff @(posedge clk) begin
        prev_idx <= idx;
        prev_val <= a_val[0];
    end

    // R1: the first cycle after reset shows a cleared register
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ctrl_q == 16'h0000);

    // R2 R3 R8: no matching strobed write leaves every bit as it was
    assert_hold_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(ctrl_q));

    // R4 R6: the addressed bit takes the data bit on the next cycle
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> ctrl_q[prev_idx] == prev_val);

    // R5: at most one bit changes per write
    assert_single_bit_R5: assert property (@(posedge clk) disable iff (rst)
        hit |=> $countones(ctrl_q ^ $past(ctrl_q)) <= 1);

    // R7: writing bit 0 drives the window enable and indicator
    assert_card_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && idx == 4'd0) |=> (card_en == prev_val) && (card_led == prev_val));

    // R7: writing bit 15 drives the auxiliary window enable
    assert_aux_follow_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && idx == 4'd15) |=> aux_en == prev_val);
endmodule

bind bitwise_ctl_reg bitwise_ctl_reg_chk i_chk (.*);

// File: tb/test_bitwise_ctl_reg.sv
`timescale 1ns/1ps
module test_bitwise_ctl_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe_n = 1'b1;
    logic [0:15] io_addr = '0;
    logic [2:0]  base_sel = 3'd0;
    logic [15:0] ctrl_q;
    logic        card_en, card_led, aux_en;

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [15:0] model = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    bitwise_ctl_reg i_bitwise_ctl_reg (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .io_addr(io_addr),
        .base_sel(base_sel), .ctrl_q(ctrl_q), .card_en(card_en),
        .card_led(card_led), .aux_en(aux_en)
    );

    function automatic logic [15:0] mk(logic [2:0] sel, int n, logic d);
        return 16'h1000 | {5'b0, sel, 8'h00} | 16'(n << 1) | {15'b0, d};
    endfunction

    // Driver: apply one cycle, update the reference from the requirements, queue it
    task automatic step(input logic r, input logic sn, input logic [2:0] sel,
                        input logic [15:0] a, input string tag);
        @(negedge clk);
        rst = r; strobe_n = sn; base_sel = sel; io_addr = a;
        @(posedge clk);
        #1;
        if (r) model = '0;
        else if (!sn && ((a & 16'h1F00) == (16'h1000 | {5'b0, sel, 8'h00})))
            model[a[4:1]] = a[0];
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare at the falling edge after each driven edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (ctrl_q !== e || card_en !== e[0] || card_led !== e[0] || aux_en !== e[15]) begin
                errors++;
                $display("FAIL %s actual=%h en=%b led=%b aux=%b expected=%h en=%b aux=%b",
                         t, ctrl_q, card_en, card_led, aux_en, e, e[0], e[15]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(1, 1, 3'd5, 16'h0000, "R1 reset");
        step(1, 1, 3'd5, 16'h0000, "R1 reset");
        // R4 R6: fill every bit with 1 at base slot 5
        for (int n = 0; n < 16; n++) step(0, 0, 3'd5, mk(3'd5, n, 1'b1), "R4 fill");
        // R5: clear one bit, others hold
        step(0, 0, 3'd5, mk(3'd5, 7, 1'b0), "R5 clear bit7");
        step(0, 0, 3'd5, mk(3'd5, 8, 1'b0), "R5 clear bit8");
        // R7: bit 0 and bit 15 to zero
        step(0, 0, 3'd5, mk(3'd5, 0, 1'b0), "R7 card off");
        step(0, 0, 3'd5, mk(3'd5, 15, 1'b0), "R7 aux off");
        // R2: strobe high, matching address
        step(0, 1, 3'd5, mk(3'd5, 3, 1'b0), "R2 no strobe");
        // R3: wrong slot, A4 set, A3 clear
        step(0, 0, 3'd5, mk(3'd4, 3, 1'b0), "R3 slot mismatch");
        step(0, 0, 3'd5, mk(3'd5, 3, 1'b0) | 16'h0800, "R3 A4 high");
        step(0, 0, 3'd5, mk(3'd5, 3, 1'b0) & 16'hEFFF, "R3 A3 low");
        // R8: don't-care bits set
        step(0, 0, 3'd5, mk(3'd5, 3, 1'b0) | 16'hE0E0, "R8 ignored bits");
        step(0, 0, 3'd5, mk(3'd5, 15, 1'b1) | 16'hA040, "R8 ignored bits aux");
        // R6: idle cycle holds
        step(0, 1, 3'd5, 16'h0000, "R6 idle hold");
        // R9: reset and write together
        step(1, 0, 3'd5, mk(3'd5, 0, 1'b1), "R9 reset beats write");
        // R3 R4: every base slot, one write in each group
        for (int s = 0; s < 8; s++) begin
            step(1, 1, 3'(s), 16'h0000, "R1 reset");
            step(0, 0, 3'(s), mk(3'(s), s, 1'b1), "R3 slot low group");
            step(0, 0, 3'(s), mk(3'(s), s + 8, 1'b1), "R4 slot high group");
            step(0, 0, 3'(s), mk(3'((s + 1) % 8), 14, 1'b1), "R3 other slot");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule